// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block sits between a bit-level CEC receiver and a host processor. The receiver hands over each complete frame on a parallel push interface: a header byte, an opcode byte, up to fourteen operand bytes, an operand count and an error flag. The queue keeps the frames in a small ring and always shows the oldest one (the head) to the host through word-spaced registers on a simple read/write bus.

The host reads one status register that holds the pending-frame count, the head's operand count and its error flag. It then reads the head's bytes and writes a control bit to discard the head. A second control bit empties the whole queue. Both control bits clear themselves once the operation has finished, so the host can poll them. A level interrupt reports that frames are waiting and that a frame was lost because the queue was full. The interrupt status bits are cleared by writing ones to them.

Top module: `cec_rxq`

## Requirements
- R1: After reset the status register (0x04), the control register (0x00), the interrupt status register (0x50) and the irq output all read zero.
- R2: Frames leave in the order they arrived. For the head frame, the header byte reads at 0x08, the opcode byte at 0x0C, and operand i (0 to 13) at 0x10 + 4·i, each in bits [7:0].
- R3: The status register at 0x04 returns the head's operand count in bits [3:0], the number of pending frames in bits [6:4] and the head's error flag in bit 7. When the queue is empty it reads zero.
- R4: Writing 1 to bit 0 of 0x00 discards the head. The bit reads 1 in the cycle after the write. The head and count change at the next clock edge, and the bit then reads 0. A discard on an empty queue changes nothing.
- R5: Writing 1 to bit 1 of 0x00 empties the queue, with the same one-cycle self-clearing read-back on bit 1.
- R6: A frame pushed with its error flag set takes a slot like any other frame. Its bytes stay readable, and it leaves only through the normal discard.
- R7: The queue holds 4 frames. A push into a full queue is dropped and leaves the stored frames unchanged. It sets bit 3 of 0x50, which stays set until the host clears it.
- R8: Bit 1 of 0x50 is set when a frame is accepted, and again after a discard that leaves frames behind. Writing 1 to a bit of 0x50 clears it, but a set in the same cycle wins over the clear.
- R9: The irq output is high exactly when some bit of 0x50 is set and the same bit of the enable register at 0x54 is 1.
- R10: A push in the same cycle as a discard takes effect along with it. The count stays the same, and the push is accepted even when the queue was full.
- R11: A push in the same cycle as a flush survives the flush and becomes the only queued frame.
- R12: Addresses outside the map read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Frame offered for one cycle |
| push_hdr | input | 8 | Header byte |
| push_opc | input | 8 | Opcode byte |
| push_ops | input | 112 | Operand bytes, operand i in bits [8i+7:8i] |
| push_len | input | 4 | Operand count |
| push_err | input | 1 | Frame received with error |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The receiver's push and the host's discard or flush can fall in the same clock edge. The bench provokes this by writing the control register and then raising push_valid in the very cycle the pending operation executes. It does this once with a full queue and a discard, and once with a flush. The expected results come from a bench-side queue model: the count is unchanged and no overflow is raised after the discard, and only the new frame is left after the flush. A push that lands in the same cycle as a write-one-to-clear of the not-empty bit is checked as well, and the bit must stay set.

// File: rtl/cecq_pkg.sv
// Shared types and register map for the CEC receive frame queue.
// Assumes byte addresses and 32-bit word-spaced registers.
package cecq_pkg;
    localparam int unsigned OPS_MAX = 14;
    localparam int unsigned LEN_W   = 4;

    typedef struct packed {
        logic                    err;
        logic [LEN_W-1:0]        len;
        logic [OPS_MAX-1:0][7:0] ops;
        logic [7:0]              opc;
        logic [7:0]              hdr;
    } cec_frame_t;

    localparam int unsigned ADR_CTRL  = 'h00;
    localparam int unsigned ADR_STAT  = 'h04;
    localparam int unsigned ADR_HDR   = 'h08;
    localparam int unsigned ADR_OPC   = 'h0C;
    localparam int unsigned ADR_OPS   = 'h10;
    localparam int unsigned ADR_ISTAT = 'h50;
    localparam int unsigned ADR_IEN   = 'h54;

    localparam int unsigned IRQ_NE_BIT  = 1;
    localparam int unsigned IRQ_OVF_BIT = 3;
endpackage

// File: rtl/cecq_ring.sv
// Ring of frame slots with push, discard-head and flush.
// Assumes pop_i and flush_i are single-cycle strobes; flush wins over pop.
// The head output is forced to zero while the ring is empty.
module cecq_ring
    import cecq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  cec_frame_t                   frame_i,
    input  logic                         pop_i,
    input  logic                         flush_i,
    output logic                         accept_o,
    output logic                         drop_o,
    output logic                         pop_done_o,
    output cec_frame_t                   head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    cec_frame_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] count;
    logic             full, room;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Space exists if not full, or a discard/flush executes this cycle.
    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        pop_done_o = pop_i && !flush_i && (count != '0);
        room       = !full || pop_done_o || flush_i;
        accept_o   = push_i && room;
        drop_o     = push_i && !room;
    end

    // Slot storage; written only on accepted pushes.
    always_ff @(posedge clk) begin
        if (accept_o) mem[wp] <= frame_i;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (accept_o) wp <= nxt(wp);
            if (flush_i) begin
                rp    <= wp;
                count <= CNT_W'(accept_o);
            end else begin
                if (pop_done_o) rp <= nxt(rp);
                count <= count + CNT_W'(accept_o) - CNT_W'(pop_done_o);
            end
        end
    end

    // Head presentation, zero when empty.
    always_comb begin
        head_o  = (count != '0) ? mem[rp] : '0;
        count_o = count;
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));
    p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> count_o == CNT_W'(DEPTH));
    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done_o && !push_i) |=> count_o == $past(count_o) - 1'b1);
    p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !push_i) |=> count_o == '0);
    p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done_o && push_i) |=> count_o == $past(count_o));
endmodule

// File: rtl/cecq_irq.sv
// Interrupt status with write-one-to-clear bits and an enable mask.
// Assumes set events take priority over a simultaneous clear.
module cecq_irq #(
    parameter int unsigned W       = 8,
    parameter int unsigned NE_BIT  = 1,
    parameter int unsigned OVF_BIT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_ne_i,
    input  logic         set_ovf_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wd_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    logic [W-1:0] stat, en, set_vec, clr_vec;

    // Event vector and clear vector for this cycle.
    always_comb begin
        set_vec          = '0;
        set_vec[NE_BIT]  = set_ne_i;
        set_vec[OVF_BIT] = set_ovf_i;
        clr_vec          = clr_we_i ? clr_mask_i : '0;
    end

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_vec) | set_vec;
            if (en_we_i) en <= en_wd_i;
        end
    end

    // Outputs.
    always_comb begin
        stat_o = stat;
        en_o   = en;
        irq_o  = |(stat & en);
    end

    p_ne_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ne_i |=> stat_o[NE_BIT]);
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[OVF_BIT] && !(clr_we_i && clr_mask_i[OVF_BIT])) |=> stat_o[OVF_BIT]);
endmodule

// File: rtl/cec_rxq.sv
// CEC receive frame queue top: register decode, self-clearing control
// strobes, ring and interrupt status. Assumes the push side offers one
// frame per pulse of push_valid; reads are combinational.
module cec_rxq
    import cecq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    input  logic [7:0]           push_hdr,
    input  logic [7:0]           push_opc,
    input  logic [OPS_MAX*8-1:0] push_ops,
    input  logic [LEN_W-1:0]     push_len,
    input  logic                 push_err,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    cec_frame_t       in_frame, head;
    logic [CNT_W-1:0] count;
    logic             accept, drop, pop_done;
    logic             pop_pend, flush_pend;
    logic             wr_ctrl, wr_istat, wr_ien;
    logic [7:0]       istat, ien;
    logic [2:0]       cnt3;

    // Pack the push interface into a frame record.
    always_comb begin
        in_frame.hdr = push_hdr;
        in_frame.opc = push_opc;
        in_frame.ops = push_ops;
        in_frame.len = push_len;
        in_frame.err = push_err;
        wr_ctrl  = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
        wr_istat = bus_we && (bus_addr == ADDR_W'(ADR_ISTAT));
        wr_ien   = bus_we && (bus_addr == ADDR_W'(ADR_IEN));
        cnt3     = 3'(count);
    end

    // Control strobes: held one cycle, executed at the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_pend   <= 1'b0;
            flush_pend <= 1'b0;
        end else begin
            pop_pend   <= wr_ctrl && bus_wdata[0];
            flush_pend <= wr_ctrl && bus_wdata[1];
        end
    end

    cecq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_valid),
        .frame_i    (in_frame),
        .pop_i      (pop_pend),
        .flush_i    (flush_pend),
        .accept_o   (accept),
        .drop_o     (drop),
        .pop_done_o (pop_done),
        .head_o     (head),
        .count_o    (count)
    );

    cecq_irq #(.W(8), .NE_BIT(IRQ_NE_BIT), .OVF_BIT(IRQ_OVF_BIT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ne_i   (accept || (pop_done && count > CNT_W'(1))),
        .set_ovf_i  (drop),
        .clr_we_i   (wr_istat),
        .clr_mask_i (bus_wdata[7:0]),
        .en_we_i    (wr_ien),
        .en_wd_i    (bus_wdata[7:0]),
        .stat_o     (istat),
        .en_o       (ien),
        .irq_o      (irq)
    );

    // Read multiplexer over the register map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL))  bus_rdata = {30'b0, flush_pend, pop_pend};
        if (bus_addr == ADDR_W'(ADR_STAT))  bus_rdata = {24'b0, head.err, cnt3, head.len};
        if (bus_addr == ADDR_W'(ADR_HDR))   bus_rdata = {24'b0, head.hdr};
        if (bus_addr == ADDR_W'(ADR_OPC))   bus_rdata = {24'b0, head.opc};
        if (bus_addr == ADDR_W'(ADR_ISTAT)) bus_rdata = {24'b0, istat};
        if (bus_addr == ADDR_W'(ADR_IEN))   bus_rdata = {24'b0, ien};
        for (int i = 0; i < OPS_MAX; i++) begin
            if (bus_addr == ADDR_W'(ADR_OPS + 4*i)) bus_rdata = {24'b0, head.ops[i]};
        end
    end

    p_pop_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_pend && !wr_ctrl) |=> !pop_pend);
    p_flush_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pend && !wr_ctrl) |=> !flush_pend);
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 8'h00) |-> !irq);
endmodule

// File: tb/sim_cec_rxq.sv
`timescale 1ns/1ps
module sim_cec_rxq;
    import cecq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 push_valid = 1'b0;
    logic [7:0]           push_hdr = '0, push_opc = '0;
    logic [OPS_MAX*8-1:0] push_ops = '0;
    logic [LEN_W-1:0]     push_len = '0;
    logic                 push_err = 1'b0;
    logic [7:0]           bus_addr = '0;
    logic                 bus_we = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 irq;

    int checks = 0, fails = 0;
    bit done = 0;
    int q[$];

    cec_rxq u0 (.*);

    always #2.5 clk = ~clk;

    function automatic logic [7:0] f_hdr(int s); return 8'(s); endfunction
    function automatic logic [7:0] f_opc(int s); return 8'(s*3 + 1); endfunction
    function automatic logic [7:0] f_op(int s, int i); return 8'(s*11 + i*29 + 5); endfunction
    function automatic logic [3:0] f_len(int s); return 4'(s % 15); endfunction
    function automatic logic       f_err(int s); return (s % 4) == 3; endfunction

    task automatic tick; @(posedge clk); @(negedge clk); endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic set_frame(input int s);
        push_hdr = f_hdr(s);
        push_opc = f_opc(s);
        push_len = f_len(s);
        push_err = f_err(s);
        for (int i = 0; i < OPS_MAX; i++) push_ops[i*8 +: 8] = f_op(s, i);
    endtask

    task automatic push(input int s);
        set_frame(s);
        push_valid = 1'b1;
        tick();
        push_valid = 1'b0;
        if (q.size() < 4) q.push_back(s);
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    // Compare every head register with the bench model.
    task automatic check_head(input string tag);
        logic [31:0] d;
        int s;
        rd(ADR_STAT, d);
        if (q.size() == 0) begin
            chk(d, 32'h0, {tag, " R3 empty status"});
        end else begin
            s = q[0];
            chk(d, {24'b0, f_err(s), 3'(q.size()), f_len(s)}, {tag, " R3/R6 status"});
            rd(ADR_HDR, d); chk(d, {24'b0, f_hdr(s)}, {tag, " R2 header"});
            rd(ADR_OPC, d); chk(d, {24'b0, f_opc(s)}, {tag, " R2 opcode"});
            for (int i = 0; i < OPS_MAX; i++) begin
                rd(ADR_OPS + 4*i, d);
                chk(d, {24'b0, f_op(s, i)}, {tag, " R2 operand"});
            end
        end
    endtask

    // Discard the head and check the self-clearing control bit (R4).
    task automatic do_pop;
        logic [31:0] d;
        bus_wr(ADR_CTRL, 32'h1);
        rd(ADR_CTRL, d); chk(d, 32'h1, "R4 pop bit busy");
        tick();
        rd(ADR_CTRL, d); chk(d, 32'h0, "R4 pop bit cleared");
        if (q.size() > 0) void'(q.pop_front());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(ADR_STAT, d);  chk(d, 0, "R1 status");
        rd(ADR_CTRL, d);  chk(d, 0, "R1 control");
        rd(ADR_ISTAT, d); chk(d, 0, "R1 int status");
        chk(32'(irq), 0, "R1 irq");

        bus_wr(ADR_IEN, 32'h0A);
        push(1);
        check_head("first");
        rd(ADR_ISTAT, d); chk(d, 32'h02, "R8 not-empty set");
        chk(32'(irq), 1, "R9 irq high");
        bus_wr(ADR_ISTAT, 32'h02);
        rd(ADR_ISTAT, d); chk(d, 32'h00, "R8 w1c");
        chk(32'(irq), 0, "R9 irq low");

        // R7 full queue drops
        push(2); push(3); push(4);
        push(5);
        check_head("R7 after drop");
        rd(ADR_ISTAT, d); chk(d, 32'h0A, "R7 overflow bit");
        bus_wr(ADR_ISTAT, 32'h02);
        rd(ADR_ISTAT, d); chk(d, 32'h08, "R7 overflow sticky");
        bus_wr(ADR_ISTAT, 32'hFF);
        do_pop();
        rd(ADR_ISTAT, d); chk(d, 32'h02, "R8 re-raised after pop");
        check_head("after pop");
        while (q.size() > 0) begin do_pop(); check_head("drain"); end

        // Sweep fill levels with varied frames, errored ones included (R6).
        seed = 10;
        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k <= r % 4; k++) begin push(seed); seed++; end
            check_head("sweep");
            while (q.size() > 0) begin do_pop(); check_head("sweep pop"); end
        end

        // R4 discard on empty
        do_pop();
        check_head("R4 empty pop");

        // R10 push together with discard on a full queue
        push(60); push(61); push(62); push(63);
        bus_wr(ADR_ISTAT, 32'hFF);
        bus_wr(ADR_CTRL, 32'h1);
        set_frame(64); push_valid = 1'b1;
        tick();
        push_valid = 1'b0;
        void'(q.pop_front()); q.push_back(64);
        rd(ADR_STAT, d); chk(d, {24'b0, f_err(61), 3'd4, f_len(61)}, "R10 count kept");
        rd(ADR_ISTAT, d); chk(d & 32'h08, 32'h0, "R10 no overflow");
        while (q.size() > 0) begin check_head("R10 order"); do_pop(); end

        // R11 push together with flush; R5 self-clear
        push(70); push(71);
        bus_wr(ADR_CTRL, 32'h2);
        rd(ADR_CTRL, d); chk(d, 32'h2, "R5 flush bit busy");
        set_frame(72); push_valid = 1'b1;
        tick();
        push_valid = 1'b0;
        q.delete(); q.push_back(72);
        rd(ADR_CTRL, d); chk(d, 32'h0, "R5 flush bit cleared");
        check_head("R11 survivor");
        push(73);
        bus_wr(ADR_CTRL, 32'h2);
        tick();
        q.delete();
        check_head("R5 flushed");

        // R8 set wins over simultaneous clear
        bus_wr(ADR_ISTAT, 32'hFF);
        set_frame(80); push_valid = 1'b1;
        bus_addr = 8'(ADR_ISTAT); bus_wdata = 32'h02; bus_we = 1'b1;
        tick();
        push_valid = 1'b0; bus_we = 1'b0;
        q.push_back(80);
        rd(ADR_ISTAT, d); chk(d, 32'h02, "R8 set beats clear");

        // R12 unmapped addresses
        rd('h48, d); chk(d, 0, "R12 read 0x48");
        rd('h60, d); chk(d, 0, "R12 read 0x60");
        bus_wr('h48, 32'hFFFF_FFFF);
        bus_wr('h58, 32'hFFFF_FFFF);
        check_head("R12 after stray writes");
        rd(ADR_ISTAT, d); chk(d, 32'h02, "R12 int status kept");

        // R9 gating by enable
        chk(32'(irq), 1, "R9 enabled");
        bus_wr(ADR_IEN, 32'h08);
        chk(32'(irq), 0, "R9 masked");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule